// File: doc/BRIEF.md
# Four-Channel Prescaled Down-Counting Timer

This block provides four independent 32-bit down-counters reached over a simple register bus: a byte address, a write enable, write data, and read data decoded combinationally from the address. Every channel counts on its own tick. The tick comes from an 8-bit prescaler, which each pair of channels shares. A per-channel power-of-two divider follows the prescaler. Software places a period and a compare level in per-channel buffers. It copies them into the live counter by pulsing a manual-update bit, then starts the channel with a run bit. An optional auto-reload bit turns the channel from one-shot into periodic.

A channel expires when it counts past zero, and each expiry latches a per-channel status flag. The flags and their enables share one register. One interrupt line goes high while any enabled flag is set. Each channel also drives a PWM line, which compares the live count against the active compare value and can be inverted.

Each channel runs a four-state machine. In IDLE the channel counts only if run is set. LOAD copies the buffers. RUN is normal counting. DONE is a one-shot that has expired. The transitions are:
- Any state except LOAD goes to LOAD when manual update is set.
- LOAD goes to RUN when update clears with run set, and to IDLE when update clears with run clear.
- IDLE goes to RUN when run is set.
- RUN goes to IDLE when run clears.
- RUN or IDLE goes to DONE on an expiry without auto-reload.
- DONE goes to IDLE when run clears.

Top module: `timer_top`

## Requirements
- R1: After reset every mapped register reads zero and the interrupt line is low.
- R2: Readable bits are as follows; all other bits read zero:
  - 0x00 bits 15:0 hold two prescaler fields. Bits 7:0 serve channels 0 and 1, and bits 15:8 serve channels 2 and 3. Each field holds the ratio minus one.
  - 0x04 bits 15:0 hold a 4-bit divider select per channel at bit 4×ch.
  - 0x08 holds a 4-bit control field per channel. The field starts at bit 0 for channel 0 and at bit 4×ch+4 for the other channels. Within the field, bit 0 is run, bit 1 is manual update, bit 2 is invert and bit 3 is auto-reload.
  - The count buffer at 0x0C+0x0C×ch and the compare buffer at 0x10+0x0C×ch hold all 32 bits.
- R3: A running channel decrements once every (P+1)×2^S clock cycles. P is its pair's prescaler field. S is its divider select; selects 5 to 15 act as 4.
- R4: While manual update is set, the counter and active compare are loaded from the buffers on every cycle and counting is suspended. The count observation register at 0x14+0x0C×ch then shows the count buffer value.
- R5: With run and auto-reload set, a channel whose count buffer holds N−1 expires every N ticks. At each expiry it reloads both the counter and the compare from the buffers.
- R6: With auto-reload clear, a channel expires once, then holds count zero and does not expire again while run stays set.
- R7: A channel with run and update clear holds its count.
- R8: Each expiry sets the channel's status bit, bit 5+ch of the register at 0x44.
- R9: At 0x44, bits 3:0 are read/write enables, one bit per channel. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set from an expiry wins over a clear in the same cycle.
- R10: The interrupt output is high exactly while some status bit and its enable are both set.
- R11: PWM of a channel is high while its count is at or below its active compare value; the invert bit flips it. After reset all PWM lines are high.
- R12: Unmapped offsets read zero and ignore writes. Writes to the count observation registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | 4 | PWM output per channel |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker assumes that the bus is driven to known values on every cycle out of reset. The status-clear property relates a falling flag to the write seen one cycle earlier, so an X on the strobe would defeat it. It also assumes the bus carries at most one write per cycle. The stimulus holds the strobe low between writes and programs the prescaler and divider fields before it starts a channel, so each measured period comes from a steady tick. Random periods start at four ticks, which leaves room for the clear write to land between two expiries.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH       = 4;
    localparam int DW        = 32;
    localparam int AW        = 8;
    localparam int PRE_W     = 8;
    localparam int SEL_W     = 4;
    localparam int MAX_SHIFT = 4;
    localparam int NPAIR     = NCH / 2;
    localparam int ST_LSB    = 5;

    localparam logic [AW-1:0] OFS_CFG0 = 8'h00;
    localparam logic [AW-1:0] OFS_CFG1 = 8'h04;
    localparam logic [AW-1:0] OFS_CTRL = 8'h08;
    localparam logic [AW-1:0] OFS_INT  = 8'h44;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LOAD,
        CH_RUN,
        CH_DONE
    } ch_state_e;

    // control nibble position: channel 0 at 0, others at 4*ch+4
    function automatic int ctrl_lsb(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    function automatic logic [AW-1:0] cntbuf_ofs(input int ch);
        return AW'(12 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] cmpbuf_ofs(input int ch);
        return AW'(16 + 12 * ch);
    endfunction

    function automatic logic [AW-1:0] obs_ofs(input int ch);
        return AW'(20 + 12 * ch);
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_m1,
    output logic         tick_o
);
    logic [W-1:0] cnt_q;
    logic         wrap;

    assign wrap   = (cnt_q >= ratio_m1);
    assign tick_o = wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_divider.sv
module tmr_divider #(
    parameter int SEL_W     = 4,
    parameter int MAX_SHIFT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    logic [MAX_SHIFT-1:0] cnt_q;
    logic [MAX_SHIFT-1:0] mask;
    logic [MAX_SHIFT:0]   one_hot;

    always_comb begin
        one_hot = (MAX_SHIFT+1)'(1) << sel;
        if (sel >= SEL_W'(MAX_SHIFT)) begin
            mask = '1;
        end else begin
            mask = MAX_SHIFT'(one_hot - 1'b1);
        end
    end

    assign tick_o = pre_tick && ((cnt_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pre_tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         upd,
    input  logic         inv,
    input  logic         auto_rl,
    input  logic [W-1:0] cnt_buf,
    input  logic [W-1:0] cmp_buf,
    output logic [W-1:0] cnt_o,
    output logic         expire_o,
    output logic         pwm_o
);
    ch_state_e    state_q, state_d;
    logic [W-1:0] cnt_q, cmp_q;
    logic         active;
    logic         expire;

    assign active = run && !upd && (state_q != CH_DONE);
    assign expire = active && tick && (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (upd) begin
                    state_d = CH_LOAD;
                end else if (run) begin
                    state_d = (expire && !auto_rl) ? CH_DONE : CH_RUN;
                end
            end
            CH_LOAD: begin
                if (!upd) begin
                    state_d = run ? CH_RUN : CH_IDLE;
                end
            end
            CH_RUN: begin
                if (upd) begin
                    state_d = CH_LOAD;
                end else if (!run) begin
                    state_d = CH_IDLE;
                end else if (expire && !auto_rl) begin
                    state_d = CH_DONE;
                end
            end
            CH_DONE: begin
                if (upd) begin
                    state_d = CH_LOAD;
                end else if (!run) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // counter and active compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else if (upd) begin
            cnt_q <= cnt_buf;
            cmp_q <= cmp_buf;
        end else if (active && tick) begin
            if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else if (auto_rl) begin
                cnt_q <= cnt_buf;
                cmp_q <= cmp_buf;
            end
        end
    end

    // outputs
    always_comb begin
        cnt_o    = cnt_q;
        expire_o = expire;
        pwm_o    = (cnt_q <= cmp_q) ^ inv;
    end
endmodule

// File: rtl/timer_top.sv
module timer_top
    import tmr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_we,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic [NCH-1:0] pwm_o,
    output logic          irq_o
);
    logic [NPAIR-1:0][PRE_W-1:0] pre_q;
    logic [NCH-1:0][SEL_W-1:0]   sel_q;
    logic [NCH-1:0]              run_v, upd_v, inv_v, auto_v;
    logic [NCH-1:0][DW-1:0]      cntb_q, cmpb_q, cnt_all;
    logic [NCH-1:0]              int_en_q, int_st_q;
    logic [NPAIR-1:0]            pre_tick;
    logic [NCH-1:0]              ch_tick, ch_exp;
    logic [NCH-1:0]              st_clr;

    // configuration and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= '0;
            sel_q    <= '0;
            run_v    <= '0;
            upd_v    <= '0;
            inv_v    <= '0;
            auto_v   <= '0;
            cntb_q   <= '0;
            cmpb_q   <= '0;
            int_en_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFS_CFG0) begin
                for (int p = 0; p < NPAIR; p++) begin
                    pre_q[p] <= bus_wdata[p*PRE_W +: PRE_W];
                end
            end
            if (bus_addr == OFS_CFG1) begin
                for (int c = 0; c < NCH; c++) begin
                    sel_q[c] <= bus_wdata[c*SEL_W +: SEL_W];
                end
            end
            if (bus_addr == OFS_CTRL) begin
                for (int c = 0; c < NCH; c++) begin
                    run_v[c]  <= bus_wdata[ctrl_lsb(c)];
                    upd_v[c]  <= bus_wdata[ctrl_lsb(c) + 1];
                    inv_v[c]  <= bus_wdata[ctrl_lsb(c) + 2];
                    auto_v[c] <= bus_wdata[ctrl_lsb(c) + 3];
                end
            end
            if (bus_addr == OFS_INT) begin
                int_en_q <= bus_wdata[NCH-1:0];
            end
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == cntbuf_ofs(c)) cntb_q[c] <= bus_wdata;
                if (bus_addr == cmpbuf_ofs(c)) cmpb_q[c] <= bus_wdata;
            end
        end
    end

    // status flags: expiry sets, write-one clears, set wins
    assign st_clr = (bus_we && bus_addr == OFS_INT) ? bus_wdata[ST_LSB +: NCH] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_st_q <= '0;
        end else begin
            int_st_q <= (int_st_q & ~st_clr) | ch_exp;
        end
    end

    assign irq_o = |(int_st_q & int_en_q);

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_CFG0) begin
            for (int p = 0; p < NPAIR; p++) begin
                bus_rdata[p*PRE_W +: PRE_W] = pre_q[p];
            end
        end
        if (bus_addr == OFS_CFG1) begin
            for (int c = 0; c < NCH; c++) begin
                bus_rdata[c*SEL_W +: SEL_W] = sel_q[c];
            end
        end
        if (bus_addr == OFS_CTRL) begin
            for (int c = 0; c < NCH; c++) begin
                bus_rdata[ctrl_lsb(c) +: 4] = {auto_v[c], inv_v[c], upd_v[c], run_v[c]};
            end
        end
        if (bus_addr == OFS_INT) begin
            bus_rdata[NCH-1:0]        = int_en_q;
            bus_rdata[ST_LSB +: NCH]  = int_st_q;
        end
        for (int c = 0; c < NCH; c++) begin
            if (bus_addr == cntbuf_ofs(c)) bus_rdata = cntb_q[c];
            if (bus_addr == cmpbuf_ofs(c)) bus_rdata = cmpb_q[c];
            if (bus_addr == obs_ofs(c))    bus_rdata = cnt_all[c];
        end
    end

    // shared prescalers
    for (genvar p = 0; p < NPAIR; p++) begin : g_pre
        tmr_prescale #(.W(PRE_W)) u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .ratio_m1 (pre_q[p]),
            .tick_o   (pre_tick[p])
        );
    end

    // per-channel divider and counter
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        tmr_divider #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .pre_tick (pre_tick[c/2]),
            .sel      (sel_q[c]),
            .tick_o   (ch_tick[c])
        );

        tmr_channel #(.W(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (ch_tick[c]),
            .run      (run_v[c]),
            .upd      (upd_v[c]),
            .inv      (inv_v[c]),
            .auto_rl  (auto_v[c]),
            .cnt_buf  (cntb_q[c]),
            .cmp_buf  (cmpb_q[c]),
            .cnt_o    (cnt_all[c]),
            .expire_o (ch_exp[c]),
            .pwm_o    (pwm_o[c])
        );
    end
endmodule

// File: rtl/timer_top_chk.sv
module timer_top_chk
    import tmr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic [AW-1:0]          bus_addr,
    input logic                   bus_we,
    input logic [DW-1:0]          bus_wdata,
    input logic [DW-1:0]          bus_rdata,
    input logic                   irq_o,
    input logic [NCH-1:0]         int_en,
    input logic [NCH-1:0]         int_st,
    input logic [NCH-1:0]         ch_exp,
    input logic [NCH-1:0]         ch_tick,
    input logic [NCH-1:0]         run_v,
    input logic [NCH-1:0]         upd_v,
    input logic [NCH-1:0][DW-1:0] cnt_all
);
    logic [NCH-1:0] clr_req;
    assign clr_req = (bus_we && bus_addr == OFS_INT) ? bus_wdata[ST_LSB +: NCH] : '0;

    // R9
    status_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((~int_st & $past(int_st)) & ~$past(clr_req)) == '0);

    // R10
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq_o);

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > OFS_INT || bus_addr == 8'h40 || bus_addr == 8'h3C) |-> (bus_rdata == '0));

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R8
        expire_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_exp[c] |=> int_st[c]);

        // R7
        stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!run_v[c] && !upd_v[c]) |-> (cnt_all[c] == $past(cnt_all[c])));

        // R3
        decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(ch_tick[c] && run_v[c] && !upd_v[c] && cnt_all[c] != '0)
            |-> (cnt_all[c] == $past(cnt_all[c]) - DW'(1)));
    end
endmodule

bind timer_top timer_top_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .int_en    (int_en_q),
    .int_st    (int_st_q),
    .ch_exp    (ch_exp),
    .ch_tick   (ch_tick),
    .run_v     (run_v),
    .upd_v     (upd_v),
    .cnt_all   (cnt_all)
);

// File: tb/timer_top_bench.sv
module timer_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    timer_top u_timer_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_o     (pwm_o),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int f_lsb(input int ch);
        return (ch == 0) ? 0 : 4 * ch + 4;
    endfunction

    function automatic int f_period(input int n, input int pre, input int sel);
        int s = (sel > 4) ? 4 : sel;
        return n * (pre + 1) * (1 << s);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // waits for irq, checking PWM of channel ch on every cycle
    task automatic wait_irq(input int ch, input logic [31:0] cmpv, input bit inv,
                            output int t, inout int pwm_bad);
        t = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            bus_addr = 8'(20 + 12 * ch);
            #1;
            if (pwm_o[ch] !== ((bus_rdata <= cmpv) ^ inv)) pwm_bad++;
            if (irq_o) begin
                t = cyc;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, a;
        int seed;
        seed = $urandom(20240611);

        repeat (3) @(negedge clk);
        // R1 reset state
        for (int k = 0; k < 18; k++) begin
            bus_rd(8'(4 * k), v);
            check("R1 reg reset", v, 32'h0);
        end
        check("R1 irq reset", {31'h0, irq_o}, 32'h0);
        check("R11 pwm reset", {28'h0, pwm_o}, 32'hF);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 readback masks
        bus_wr(8'h00, 32'hFFFF_FFFF); bus_rd(8'h00, v); check("R2 cfg0", v, 32'h0000_FFFF);
        bus_wr(8'h04, 32'hFFFF_FFFF); bus_rd(8'h04, v); check("R2 cfg1", v, 32'h0000_FFFF);
        bus_wr(8'h08, 32'hFFFF_FFFF); bus_rd(8'h08, v); check("R2 ctrl", v, 32'h000F_FF0F);
        bus_wr(8'h08, 32'h0);
        bus_wr(8'h30, 32'hDEAD_BEEF); bus_rd(8'h30, v); check("R2 cnt buf ch3", v, 32'hDEAD_BEEF);
        bus_wr(8'h44, 32'hFFFF_FFFF); bus_rd(8'h44, v); check("R9 enables rw", v, 32'h0000_000F);
        bus_wr(8'h44, 32'h0);

        // R6 one-shot on channel 1, then R9/R10 flag handling
        bus_wr(8'h00, 32'h0);
        bus_wr(8'h04, 32'h0);
        bus_wr(8'h18, 32'd4);
        bus_wr(8'h1C, 32'd2);
        bus_wr(8'h08, 32'h200);
        bus_wr(8'h08, 32'h100);
        repeat (30) @(negedge clk);
        bus_rd(8'h20, v); check("R6 holds zero", v, 32'h0);
        bus_rd(8'h44, v); check("R8 status ch1", v, 32'h40);
        bus_wr(8'h44, 32'h2); bus_rd(8'h44, v); check("R9 write zero keeps", v, 32'h42);
        check("R10 irq enabled", {31'h0, irq_o}, 32'h1);
        bus_wr(8'h44, 32'h0); bus_rd(8'h44, v);
        check("R10 irq masked", {31'h0, irq_o}, 32'h0);
        check("R9 status kept", v, 32'h40);
        bus_wr(8'h44, 32'h40); bus_rd(8'h44, v); check("R9 w1c", v, 32'h0);
        repeat (20) @(negedge clk);
        bus_rd(8'h44, v); check("R6 no re-expiry", v, 32'h0);

        // R12 unmapped and read-only observation
        bus_wr(8'h20, 32'h1234); bus_rd(8'h20, v); check("R12 obs read-only", v, 32'h0);
        bus_wr(8'h40, 32'hFFFF_FFFF); bus_rd(8'h40, v); check("R12 unmapped 0x40", v, 32'h0);
        bus_rd(8'hFC, v); check("R12 unmapped 0xFC", v, 32'h0);
        bus_rd(8'h00, v); check("R12 no side effect", v, 32'h0);

        // random periodic trials
        for (int t = 0; t < 10; t++) begin
            int ch    = $urandom_range(0, 3);
            int pre   = $urandom_range(0, 3);
            int other = $urandom_range(0, 3);
            int sel   = $urandom_range(0, 6);
            int n     = $urandom_range(4, 7);
            int cmpv  = $urandom_range(0, n);
            bit inv   = 1'($urandom_range(0, 1));
            int lsb   = f_lsb(ch);
            int t1, t2;
            int pwm_bad = 0;
            logic [31:0] cfg0, cfg1;

            cfg0 = (ch < 2) ? {16'h0, 8'(other), 8'(pre)} : {16'h0, 8'(pre), 8'(other)};
            cfg1 = 32'($urandom_range(0, 16'hFFFF));
            cfg1[4*ch +: 4] = 4'(sel);

            bus_wr(8'h08, 32'h0);
            bus_wr(8'h44, 32'h1E0);
            bus_wr(8'h44, 32'h1 << ch);
            bus_wr(8'h00, cfg0);
            bus_wr(8'h04, cfg1);
            bus_wr(8'(12 + 12 * ch), 32'(n - 1));
            bus_wr(8'(16 + 12 * ch), 32'(cmpv));
            bus_wr(8'h08, 32'h2 << lsb);
            repeat (2) @(negedge clk);
            bus_rd(8'(20 + 12 * ch), v);
            check("R4 manual update load", v, 32'(n - 1));
            bus_wr(8'h08, (32'h9 | (32'(inv) << 2)) << lsb);
            wait_irq(ch, 32'(cmpv), inv, t1, pwm_bad);
            bus_wr(8'h44, (32'h1 << (5 + ch)) | (32'h1 << ch));
            wait_irq(ch, 32'(cmpv), inv, t2, pwm_bad);
            check("R5 R3 period", 32'(t2 - t1), 32'(f_period(n, pre, sel)));
            check("R11 pwm level", 32'(pwm_bad), 32'h0);
            bus_wr(8'h08, 32'h0);
            bus_rd(8'(20 + 12 * ch), a);
            repeat (17) @(negedge clk);
            bus_rd(8'(20 + 12 * ch), v);
            check("R7 stopped hold", v, a);
        end

        finish_run();
    end
endmodule